// File: doc/BRIEF.md
# Warp Operand Gather and Lane Dispatch Stage

This block sits between the decoded instruction stream and the execution units of a SIMT core. It takes one warp instruction at a time. Each instruction carries one to three source operand descriptors and a destination tag. The block then walks the instruction through three phases: operand gather, lane-group dispatch, and a fixed-latency execution pipe followed by writeback. No arithmetic is performed. The block only reproduces, cycle for cycle, when each resource is busy and when the result becomes available.

During gather, register and shared-memory operands go through the single-ported register bank one after another. That bank runs at half the core clock. Constant operands are fetched on a separate path in parallel with the serial reads. Gather ends when both paths are finished. The 32 lanes are then issued in groups of `UNITS` lanes, one group per core cycle. After the last group, results take `PIPE_LAT` cycles in the pipe plus a writeback of one or two register-file cycles. Completion is signalled by a one-cycle pulse that carries the destination tag. The stage accepts a new instruction as soon as dispatch of the previous one ends, so several instructions can be in the pipe at once.

Top module: `warp_issue_gather`

## Requirements
- R1: During and right after reset, `in_ready` is high, and `rf_busy`, `cmem_busy`, `grp_valid` and `done` are low.
- R2: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for exactly G+D cycles. G is the gather length and D = ceil(LANES/UNITS).
- R3: Slot i of `in_kind` is bits [2i+1:2i], and only slots below `in_nsrc` (1 to 3) are used. The codes are 00 for a 32-bit register, 01 for a 64-bit register, 10 for a constant and 11 for shared memory. Non-constant slots are read one at a time in ascending slot order, starting in the cycle after acceptance. A 32-bit register read holds `rf_busy` for 2 cycles with `rf_slot` equal to the slot, and a 64-bit register read holds it for 4 cycles.
- R4: Each constant slot costs 4 cycles on a parallel path that starts with gather, and `cmem_busy` is high while that path runs. G is the larger of the serial total and the constant total.
- R5: A shared-memory slot occupies the serial path for 2+SHM_EXTRA cycles (6 by default).
- R6: Right after gather, `grp_valid` is high for D consecutive cycles, and `grp_idx` counts 0 to D-1 during them.
- R7: `done` rises exactly A+G+D+PIPE_LAT+W cycles after acceptance edge A. W is 2 for a 32-bit destination and 4 when `in_wide` is set.
- R8: `done` lasts a single cycle and `done_tag` equals the tag given at acceptance.
- R9: A new instruction can be accepted the cycle after the previous dispatch ends. Completions then arrive in acceptance order.
- R10: While `in_ready` is low, `in_valid` and the operand fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Stage idle, able to accept |
| in_nsrc | input | 2 | Number of source operands, 1 to 3 |
| in_kind | input | 6 | Per-slot operand source code, 2 bits per slot |
| in_wide | input | 1 | Destination is 64-bit |
| in_tag | input | TAG_W | Destination tag |
| rf_busy | output | 1 | Register bank serially reading an operand |
| rf_slot | output | 2 | Slot currently read from the register bank |
| cmem_busy | output | 1 | Constant path fetching |
| grp_valid | output | 1 | A lane group is issued this cycle |
| grp_idx | output | GW | Index of the issued lane group |
| done | output | 1 | Result written back, one-cycle pulse |
| done_tag | output | TAG_W | Tag of the completed instruction |

## Verification
The operand patterns are chosen so that each one isolates a different gather effect:
- A single 32-bit read against three 64-bit reads separates the per-width serial cost.
- A constant alone, and a constant beside a short register read, show that the parallel path hides the serial path, or is the one that sets G.
- A pattern whose register reads outlast the constant shows the serial path setting G instead.
- Shared slots separate the added arbitration cost from a plain register read.
- Wide and narrow destinations separate the two writeback lengths.

Back-to-back issue with junk held on the inputs while busy shows two things. Instructions overlap in the pipe with completions in order, and nothing offered during gather or dispatch leaks into the outputs.

// File: rtl/warp_issue_gather.sv
module warp_issue_gather #(
  parameter int LANES     = 32,
  parameter int UNITS     = 8,
  parameter int PIPE_LAT  = 10,
  parameter int SHM_EXTRA = 4,
  parameter int RF_RATIO  = 2,
  parameter int TAG_W     = 6,
  localparam int NGRP     = (LANES + UNITS - 1) / UNITS,
  localparam int GW       = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_nsrc,
  input  logic [5:0]       in_kind,
  input  logic             in_wide,
  input  logic [TAG_W-1:0] in_tag,
  output logic             rf_busy,
  output logic [1:0]       rf_slot,
  output logic             cmem_busy,
  output logic             grp_valid,
  output logic [GW-1:0]    grp_idx,
  output logic             done,
  output logic [TAG_W-1:0] done_tag
);

  localparam int CW = 8;
  localparam int DL = PIPE_LAT + 2 * RF_RATIO + 1;
  localparam logic [1:0] K_R32 = 2'd0, K_R64 = 2'd1, K_CON = 2'd2, K_SHM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_GATH, S_DISP} st_t;

  st_t              st;
  logic [5:0]       kinds_q;
  logic [1:0]       nsrc_q;
  logic             wide_q;
  logic [TAG_W-1:0] tag_q;
  logic             ser_on;
  logic [1:0]       slot_q;
  logic [CW-1:0]    scnt, ccnt;
  logic [GW-1:0]    gcnt;
  logic [DL-1:0]    dl_v;
  logic [TAG_W-1:0] dl_t [DL];

  function automatic logic [CW-1:0] cost(input logic [1:0] k);
    case (k)
      K_R32:   return CW'(RF_RATIO);
      K_R64:   return CW'(2 * RF_RATIO);
      K_SHM:   return CW'(RF_RATIO + SHM_EXTRA);
      default: return '0;
    endcase
  endfunction

  function automatic logic [2:0] next_ser(input logic [5:0] k, input logic [1:0] n, input int from);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 2; i >= 0; i--)
      if (i >= from && i < int'(n) && k[2*i +: 2] != K_CON) r = {1'b1, 2'(i)};
    return r;
  endfunction

  function automatic int nconst(input logic [5:0] k, input logic [1:0] n);
    int c;
    c = 0;
    for (int i = 0; i < 3; i++)
      if (i < int'(n) && k[2*i +: 2] == K_CON) c++;
    return c;
  endfunction

  logic       acc, ser_last, con_last, ins;
  logic [2:0] first, nxt;
  int         ins_idx;

  assign acc      = in_valid && in_ready;
  assign first    = next_ser(in_kind, in_nsrc, 0);
  assign nxt      = next_ser(kinds_q, nsrc_q, int'(slot_q) + 1);
  assign ser_last = !ser_on || (scnt == '0 && !nxt[2]);
  assign con_last = ccnt <= CW'(1);
  assign ins      = (st == S_DISP) && (gcnt == GW'(NGRP - 1));
  assign ins_idx  = PIPE_LAT + (wide_q ? 2 * RF_RATIO : RF_RATIO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kinds_q <= '0;
      nsrc_q  <= '0;
      wide_q  <= 1'b0;
      tag_q   <= '0;
      ser_on  <= 1'b0;
      slot_q  <= '0;
      scnt    <= '0;
      ccnt    <= '0;
      gcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (acc) begin
          st      <= S_GATH;
          kinds_q <= in_kind;
          nsrc_q  <= in_nsrc;
          wide_q  <= in_wide;
          tag_q   <= in_tag;
          ser_on  <= first[2];
          slot_q  <= first[1:0];
          scnt    <= cost(in_kind[int'(first[1:0])*2 +: 2]) - CW'(1);
          ccnt    <= CW'(nconst(in_kind, in_nsrc) * 2 * RF_RATIO);
        end
        S_GATH: begin
          if (ser_last && con_last) begin
            st   <= S_DISP;
            gcnt <= '0;
          end
          if (ccnt != '0) ccnt <= ccnt - CW'(1);
          if (ser_on) begin
            if (scnt == '0) begin
              ser_on <= nxt[2];
              if (nxt[2]) begin
                slot_q <= nxt[1:0];
                scnt   <= cost(kinds_q[int'(nxt[1:0])*2 +: 2]) - CW'(1);
              end
            end else begin
              scnt <= scnt - CW'(1);
            end
          end
        end
        S_DISP: begin
          if (ins) st <= S_IDLE;
          else     gcnt <= gcnt + GW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_v <= '0;
      for (int i = 0; i < DL; i++) dl_t[i] <= '0;
    end else begin
      for (int i = 0; i < DL - 1; i++) begin
        dl_v[i] <= dl_v[i+1];
        dl_t[i] <= dl_t[i+1];
      end
      dl_v[DL-1] <= 1'b0;
      if (ins) begin
        dl_v[ins_idx] <= 1'b1;
        dl_t[ins_idx] <= tag_q;
      end
    end
  end

  assign in_ready  = (st == S_IDLE);
  assign rf_busy   = (st == S_GATH) && ser_on;
  assign rf_slot   = slot_q;
  assign cmem_busy = (st == S_GATH) && (ccnt != '0);
  assign grp_valid = (st == S_DISP);
  assign grp_idx   = gcnt;
  assign done      = dl_v[0];
  assign done_tag  = dl_t[0];

  a_r2_hold_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_busy && $past(rf_busy) && rf_slot != $past(rf_slot)) |-> (rf_slot > $past(rf_slot)));

  a_r4_wait_const: assert property (@(posedge clk) disable iff (!rst_n)
    (cmem_busy && ccnt > CW'(1)) |=> (st == S_GATH));

  a_r6_group_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_valid) |-> (grp_idx == '0));

  a_r6_group_step: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && $past(grp_valid)) |-> (grp_idx == $past(grp_idx) + GW'(1)));

  a_r2_ready_after_groups: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grp_valid) |-> in_ready);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_warp_issue_gather.sv
module test_warp_issue_gather;
  localparam int P = 10, U = 8, LN = 32, SX = 4, RF = 2, TW = 6;
  localparam int NG = (LN + U - 1) / U;
  localparam int GW = (NG > 1) ? $clog2(NG) : 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_wide, rf_busy, cmem_busy, grp_valid, done;
  logic [1:0] in_nsrc, rf_slot;
  logic [5:0] in_kind;
  logic [TW-1:0] in_tag, done_tag;
  logic [GW-1:0] grp_idx;

  warp_issue_gather #(.LANES(LN), .UNITS(U), .PIPE_LAT(P), .SHM_EXTRA(SX), .RF_RATIO(RF), .TAG_W(TW)) i_warp_issue_gather (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_nsrc(in_nsrc),
    .in_kind(in_kind), .in_wide(in_wide), .in_tag(in_tag), .rf_busy(rf_busy), .rf_slot(rf_slot),
    .cmem_busy(cmem_busy), .grp_valid(grp_valid), .grp_idx(grp_idx), .done(done), .done_tag(done_tag));

  int cyc = 0, checks = 0, errors = 0;
  bit e_busy[int], e_rd[int], e_cm[int], e_gv[int];
  int e_slot[int], e_gi[int], e_dt[int];
  int tagq[$];

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    chk(cyc < 2 ? "R1" : (in_valid && e_busy.exists(cyc)) ? "R10" : "R2", int'(in_ready), int'(!e_busy.exists(cyc)));
    chk("R3 R5", int'(rf_busy), int'(e_rd.exists(cyc)));
    if (e_rd.exists(cyc)) chk("R3", int'(rf_slot), e_slot[cyc]);
    chk("R4", int'(cmem_busy), int'(e_cm.exists(cyc)));
    chk("R6", int'(grp_valid), int'(e_gv.exists(cyc)));
    if (e_gv.exists(cyc)) chk("R6", int'(grp_idx), e_gi[cyc]);
    chk("R7", int'(done), int'(e_dt.exists(cyc)));
    if (e_dt.exists(cyc)) chk("R8", int'(done_tag), e_dt[cyc]);
    if (done) begin
      if (tagq.size() == 0) chk("R9", int'(done_tag), -1);
      else chk("R9", int'(done_tag), tagq.pop_front());
    end
  end

  task automatic plan(input int a, input int n, input logic [5:0] k, input logic w, input int t);
    int t0, nc, g, c;
    t0 = a; nc = 0;
    for (int s = 0; s < n; s++) begin
      int kd = int'(k[2*s +: 2]);
      if (kd == 2) nc++;
      else begin
        c = (kd == 0) ? RF : (kd == 1) ? 2*RF : RF + SX;
        for (int j = 0; j < c; j++) begin e_rd[t0+j] = 1; e_slot[t0+j] = s; end
        t0 += c;
      end
    end
    c = nc * 2 * RF;
    g = (t0 - a > c) ? t0 - a : c;
    for (int i = 0; i < c; i++) e_cm[a+i] = 1;
    for (int i = 0; i < g + NG; i++) e_busy[a+i] = 1;
    for (int i = 0; i < NG; i++) begin e_gv[a+g+i] = 1; e_gi[a+g+i] = i; end
    e_dt[a + g + NG + P + (w ? 2*RF : RF)] = t;
    tagq.push_back(t);
  endtask

  task automatic issue(input logic [1:0] n, input logic [5:0] k, input logic w, input logic [TW-1:0] t, input bit junk);
    @(negedge clk);
    while (e_busy.exists(cyc)) begin
      in_valid = junk; in_nsrc = n; in_kind = ~k; in_wide = ~w; in_tag = ~t;
      @(negedge clk);
    end
    in_valid = 1'b1; in_nsrc = n; in_kind = k; in_wide = w; in_tag = t;
    plan(cyc + 1, int'(n), k, w, int'(t));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_nsrc = 2'd1; in_kind = '0; in_wide = 1'b0; in_tag = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'(in_ready), 1);
    chk("R1", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(2'd1, 6'b00_00_00, 1'b0, 6'd1, 1'b0);   // R3 single 32-bit read
    repeat (30) @(negedge clk);
    issue(2'd3, 6'b01_01_01, 1'b0, 6'd2, 1'b0);   // R3 three 64-bit reads
    repeat (30) @(negedge clk);
    issue(2'd1, 6'b00_00_10, 1'b0, 6'd3, 1'b0);   // R4 constant only
    repeat (30) @(negedge clk);
    issue(2'd2, 6'b00_10_00, 1'b0, 6'd4, 1'b0);   // R4 constant hides short read
    repeat (30) @(negedge clk);
    issue(2'd3, 6'b10_01_01, 1'b0, 6'd5, 1'b0);   // R4 serial path longer
    repeat (30) @(negedge clk);
    issue(2'd2, 6'b00_00_11, 1'b0, 6'd6, 1'b0);   // R5 shared then register
    repeat (30) @(negedge clk);
    issue(2'd3, 6'b10_10_10, 1'b1, 6'd7, 1'b0);   // R4 R7 three constants, wide
    repeat (30) @(negedge clk);
    issue(2'd3, 6'b11_10_00, 1'b1, 6'd8, 1'b0);   // R5 R7 mixed
    // R9 R10: back-to-back with junk held while busy
    issue(2'd1, 6'b00_00_01, 1'b1, 6'd9, 1'b1);
    issue(2'd1, 6'b00_00_00, 1'b0, 6'd10, 1'b1);
    issue(2'd2, 6'b00_10_11, 1'b1, 6'd11, 1'b1);
    issue(2'd1, 6'b00_00_10, 1'b0, 6'd12, 1'b1);
    repeat (60) @(negedge clk);
    chk("R9", tagq.size(), 0);
    finish_run();
  end
endmodule